// File: doc/BRIEF.md
# Two-Wire Register Read Master

This block runs one read session on a simplified two-wire serial bus. A one-cycle `go` request in the idle state latches a target address and a register index. The block then pulls the data line low while the clock line is high, which opens the session, and toggles the clock line on every system clock edge. It sends the target address, waits for the target to accept it, sends the register index, reads one byte back, acknowledges it, and closes the session with a stop.

The data line is modelled as a pad with a separate output value, output enable and input value. A small line watcher sees the start and stop edges that the master makes on the resolved line and keeps a session-active flag. The sequencer uses this flag to leave the start state and to finish the session. In this bus an acknowledge of 1 means the target accepts the transfer. If the target rejects the address, the address is sent again with no new start until it is accepted. If the target rejects the register index, the session ends with an error flag. It does not hang.

Top module: `twr_master`

## Requirements
- R1: After reset, `scl` = 1, `sda_oe` = 1, `sda_o` = 1, `done` = 0, `ack_err` = 0 and `rd_data` = 0.
- R2: A `go` pulse while idle opens a session: the data line falls while `scl` stays high. A `go` pulse during a session is ignored: no second start occurs and the address in use does not change.
- R3: Outside a session `scl` stays at 1. Inside a session `scl` never stays low for two consecutive cycles.
- R4: Inside a session the data line changes only on edges where `scl` goes low. The one exception is the rising edge of the closing stop.
- R5: Bit slots 1 to 7 carry the target address, most significant bit first. Slot 8 carries a read bit of 1. The target samples each slot while `scl` is high.
- R6: In slot 9 `sda_oe` is 0 and the target's acknowledge is read. A 1 moves on to the register index. A 0 sends the same address again from slot 1, with no new start condition.
- R7: Slots 10 to 17 carry the register index, most significant bit first. In slot 18 `sda_oe` is 0 and a second acknowledge is read.
- R8: After a register acknowledge of 1, slots 19 to 26 are released (`sda_oe` = 0) and read as the data byte, most significant bit first. In slot 27 the master drives 1 as its acknowledge.
- R9: The session ends with the data line driven low while `scl` is low, then raised while `scl` is high. `done` goes high for exactly one cycle, two cycles after the stop edge.
- R10: `rd_data` changes only together with `done`. After a successful session it shows the received byte.
- R11: A register acknowledge of 0 still ends the session with a stop and `done`. `ack_err` is set to 1 together with `done`, `rd_data` keeps its previous value, and the next `go` clears `ack_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | One-cycle request to start a read session |
| tgt_addr | input | ADDR_W | Target address, latched on an accepted `go` |
| reg_idx | input | IDX_W | Register index, latched on an accepted `go` |
| sda_i | input | 1 | Data line value seen at the pad |
| scl | output | 1 | Bus clock line |
| sda_o | output | 1 | Value the master drives on the data line |
| sda_oe | output | 1 | 1 = master drives the data line, 0 = released |
| rd_data | output | DATA_W | Last byte received |
| done | output | 1 | One-cycle pulse at the end of every session |
| ack_err | output | 1 | Register acknowledge failed in the last session |

## Verification
The assertions assume that the target changes `sda_i` only while `scl` is low, and that nothing else pulls the line while the master drives it. Under that assumption, every edge on the line with the clock high was made by the master itself. The bench's target model sets its reply only on the sample that follows a falling `scl`, and otherwise leaves the line released at 1. It keeps a slot counter in step with the master, including the return to slot 1 after a rejected address. Tests raise `go` only for one cycle. The bench pulses `go` mid-session only on purpose, to check that the pulse is ignored.

// File: rtl/twr_pkg.sv
package twr_pkg;

    // Sequencer phases of one read session
    typedef enum logic [2:0] {
        PH_IDLE,   // bus quiet, clock high
        PH_START,  // data line pulled low, waiting for the watcher
        PH_RUN,    // clocking bit slots
        PH_STOP,   // data held low, bringing clock high
        PH_DRAIN   // stop made, waiting for the watcher to close
    } phase_e;

endpackage

// File: rtl/twr_line_watch.sv
// Watches the resolved bus lines for start and stop edges and keeps the
// session-active flag.
module twr_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic active_o
);

    typedef struct packed {
        logic scl;
        logic sda;
        logic active;
    } watch_t;

    watch_t w_d, w_q;
    logic   start_seen;
    logic   stop_seen;

    always_comb begin
        start_seen = w_q.scl && scl_i && w_q.sda && !sda_i;
        stop_seen  = w_q.scl && scl_i && !w_q.sda && sda_i;
        w_d        = w_q;
        w_d.scl    = scl_i;
        w_d.sda    = sda_i;
        if (start_seen) begin
            w_d.active = 1'b1;
        end else if (stop_seen) begin
            w_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{scl: 1'b1, sda: 1'b1, active: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign active_o = w_q.active;

endmodule

// File: rtl/twr_seq.sv
// Bit-slot sequencer: one counter walks the address, index and data slots.
module twr_seq
    import twr_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              sda_in_i,
    input  logic              active_i,
    output logic              scl_o,
    output logic              sda_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] rd_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int AACK   = ADDR_W + 2;
    localparam int IFIRST = AACK + 1;
    localparam int ILAST  = AACK + IDX_W;
    localparam int IACK   = ILAST + 1;
    localparam int DFIRST = IACK + 1;
    localparam int DLAST  = IACK + DATA_W;
    localparam int MACK   = DLAST + 1;
    localparam int CNT_W  = $clog2(MACK + 1);
    localparam int TX_W   = (ADDR_W + 1 > IDX_W) ? ADDR_W + 1 : IDX_W;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t C_ONE    = cnt_t'(1);
    localparam cnt_t C_AACK   = cnt_t'(AACK);
    localparam cnt_t C_IFIRST = cnt_t'(IFIRST);
    localparam cnt_t C_IACK   = cnt_t'(IACK);
    localparam cnt_t C_DFIRST = cnt_t'(DFIRST);
    localparam cnt_t C_DLAST  = cnt_t'(DLAST);
    localparam cnt_t C_MACK   = cnt_t'(MACK);

    typedef struct packed {
        phase_e            ph;
        logic              scl;
        logic              sda;
        logic              oe;
        cnt_t              cnt;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [TX_W-1:0]   tx;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rd;
        logic              done;
        logic              bad;
        logic              err;
    } seq_t;

    seq_t            s_d, s_q;
    cnt_t            nxt;
    logic [TX_W-1:0] addr_frame;
    logic [TX_W-1:0] idx_frame;

    always_comb begin
        // frames left-aligned so the first bit is always the top bit
        addr_frame = TX_W'({s_q.addr, 1'b1}) << (TX_W - ADDR_W - 1);
        idx_frame  = TX_W'(s_q.idx) << (TX_W - IDX_W);
        nxt        = s_q.cnt + C_ONE;
        s_d        = s_q;
        s_d.done   = 1'b0;

        case (s_q.ph)
            PH_IDLE: begin
                s_d.scl = 1'b1;
                s_d.sda = 1'b1;
                s_d.oe  = 1'b1;
                if (go_i) begin
                    s_d.addr = addr_i;
                    s_d.idx  = idx_i;
                    s_d.bad  = 1'b0;
                    s_d.err  = 1'b0;
                    s_d.cnt  = '0;
                    s_d.sda  = 1'b0;   // start: fall while clock high
                    s_d.ph   = PH_START;
                end
            end

            PH_START: begin
                s_d.scl = 1'b1;
                if (active_i) begin
                    s_d.ph = PH_RUN;
                end
            end

            PH_RUN: begin
                if (!s_q.scl) begin
                    s_d.scl = 1'b1;
                end else begin
                    // step edge: sample the slot just clocked, present the next
                    s_d.scl = 1'b0;
                    if (s_q.cnt == C_AACK) begin
                        s_d.oe = 1'b1;
                        if (sda_in_i) begin
                            s_d.cnt = C_IFIRST;
                            s_d.sda = idx_frame[TX_W-1];
                            s_d.tx  = idx_frame << 1;
                        end else begin
                            s_d.cnt = C_ONE;
                            s_d.sda = addr_frame[TX_W-1];
                            s_d.tx  = addr_frame << 1;
                        end
                    end else if (s_q.cnt == C_IACK) begin
                        if (sda_in_i) begin
                            s_d.cnt = C_DFIRST;
                            s_d.oe  = 1'b0;
                            s_d.sda = 1'b1;
                        end else begin
                            s_d.bad = 1'b1;
                            s_d.oe  = 1'b1;
                            s_d.sda = 1'b0;
                            s_d.ph  = PH_STOP;
                        end
                    end else if (s_q.cnt >= C_DFIRST && s_q.cnt <= C_DLAST) begin
                        s_d.sh  = {s_q.sh[DATA_W-2:0], sda_in_i};
                        s_d.cnt = nxt;
                        if (nxt == C_MACK) begin
                            s_d.oe  = 1'b1;
                            s_d.sda = 1'b1;
                        end
                    end else if (s_q.cnt == C_MACK) begin
                        s_d.oe  = 1'b1;
                        s_d.sda = 1'b0;
                        s_d.ph  = PH_STOP;
                    end else begin
                        s_d.cnt = nxt;
                        if (s_q.cnt == '0) begin
                            s_d.oe  = 1'b1;
                            s_d.sda = addr_frame[TX_W-1];
                            s_d.tx  = addr_frame << 1;
                        end else if (nxt == C_AACK || nxt == C_IACK) begin
                            s_d.oe  = 1'b0;
                            s_d.sda = 1'b1;
                        end else begin
                            s_d.sda = s_q.tx[TX_W-1];
                            s_d.tx  = s_q.tx << 1;
                        end
                    end
                end
            end

            PH_STOP: begin
                if (!s_q.scl) begin
                    s_d.scl = 1'b1;
                end else begin
                    s_d.sda = 1'b1;    // stop: rise while clock high
                    s_d.ph  = PH_DRAIN;
                end
            end

            PH_DRAIN: begin
                s_d.scl = 1'b1;
                if (!active_i) begin
                    s_d.done = 1'b1;
                    s_d.err  = s_q.bad;
                    s_d.cnt  = '0;
                    s_d.ph   = PH_IDLE;
                    if (!s_q.bad) begin
                        s_d.rd = s_q.sh;
                    end
                end
            end

            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ph  <= PH_IDLE;
            s_q.scl <= 1'b1;
            s_q.sda <= 1'b1;
            s_q.oe  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_o  = s_q.scl;
    assign sda_o  = s_q.sda;
    assign oe_o   = s_q.oe;
    assign rd_o   = s_q.rd;
    assign done_o = s_q.done;
    assign err_o  = s_q.err;

endmodule

// File: rtl/twr_master.sv
// Read-only two-wire master: line watcher plus slot sequencer.
module twr_master #(
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              sda_i,
    output logic              scl,
    output logic              sda_o,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              ack_err
);

    logic line_sda;
    logic active;

    // resolved data line as the pad sees it
    assign line_sda = sda_oe ? sda_o : sda_i;

    twr_line_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (line_sda),
        .active_o (active)
    );

    twr_seq #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .addr_i   (tgt_addr),
        .idx_i    (reg_idx),
        .sda_in_i (sda_i),
        .active_i (active),
        .scl_o    (scl),
        .sda_o    (sda_o),
        .oe_o     (sda_oe),
        .rd_o     (rd_data),
        .done_o   (done),
        .err_o    (ack_err)
    );

endmodule

// File: rtl/twr_master_chk.sv
module twr_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl,
    input logic              sda_o,
    input logic              sda_oe,
    input logic              done,
    input logic              ack_err,
    input logic [DATA_W-1:0] rd_data
);

    logic scl_p, sda_p, oe_p;
    logic in_sess_q;
    logic hi_fall, hi_rise;

    assign hi_fall = scl && scl_p && sda_oe && oe_p && sda_p && !sda_o;
    assign hi_rise = scl && scl_p && sda_oe && oe_p && !sda_p && sda_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p     <= 1'b1;
            sda_p     <= 1'b1;
            oe_p      <= 1'b1;
            in_sess_q <= 1'b0;
        end else begin
            scl_p <= scl;
            sda_p <= sda_o;
            oe_p  <= sda_oe;
            if (hi_fall) begin
                in_sess_q <= 1'b1;
            end else if (done) begin
                in_sess_q <= 1'b0;
            end
        end
    end

    // R3
    scl_low_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scl |=> scl);

    // R2
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_fall |-> !in_sess_q);

    // R4
    rise_only_as_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rise |-> in_sess_q);

    // R9
    stop_done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rise |-> ##2 done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    data_moves_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> done);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_err) |-> done);

    // R11
    err_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ack_err) |-> $stable(rd_data));

endmodule

bind twr_master twr_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl),
    .sda_o   (sda_o),
    .sda_oe  (sda_oe),
    .done    (done),
    .ack_err (ack_err),
    .rd_data (rd_data)
);

// File: tb/test_twr_master.sv
`timescale 1ns/1ps
module test_twr_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [6:0] tgt_addr = '0;
    logic [7:0] reg_idx = '0;
    logic       sda_i = 1'b1;
    logic       scl, sda_o, sda_oe, done, ack_err;
    logic [7:0] rd_data;
    logic       line;

    always #2.5 clk = ~clk;   // 200 MHz

    twr_master i_twr_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .tgt_addr (tgt_addr),
        .reg_idx  (reg_idx),
        .sda_i    (sda_i),
        .scl      (scl),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .rd_data  (rd_data),
        .done     (done),
        .ack_err  (ack_err)
    );

    assign line = sda_oe ? sda_o : sda_i;

    int checks = 0;
    int errs   = 0;

    // target model and bus monitor state
    int         n = 0;
    logic       prev_scl = 1'b1, prev_line = 1'b1, prev_done = 1'b0;
    logic       in_sess = 1'b0;
    int         bitno = 0;
    logic       nacked = 1'b0;
    int         nacks_left = 0;
    logic       iack = 1'b1;
    logic [7:0] tbyte = '0;
    int         starts = 0, stops = 0, frames = 0, done_cnt = 0;
    int         illegal = 0, low2 = 0, idle_low = 0, rel_bad = 0, wide = 0;
    int         stop_n = 0, gap = 0;
    logic [7:0] cap_a = '0, cap_i = '0;
    logic       mack = 1'b0;

    always @(negedge clk) begin
        n = n + 1;
        if (rst_n) begin
            if (prev_scl && scl && prev_line && !line) begin
                if (in_sess) illegal++;
                starts++; in_sess = 1'b1; bitno = 0; nacked = 1'b0;
            end else if (prev_scl && scl && !prev_line && line) begin
                if (!in_sess) illegal++;
                stops++; in_sess = 1'b0; stop_n = n; sda_i = 1'b1;
            end
            if (!prev_scl && !scl) low2++;
            if (!in_sess && !scl) idle_low++;
            if (in_sess && prev_scl && !scl) begin
                if (bitno == 9 && nacked) bitno = 1; else bitno++;
                nacked = 1'b0;
                if (bitno == 9) begin
                    frames++;
                    if (nacks_left > 0) begin
                        sda_i = 1'b0; nacks_left--; nacked = 1'b1;
                    end else sda_i = 1'b1;
                end else if (bitno == 18) sda_i = iack;
                else if (bitno >= 19 && bitno <= 26) sda_i = tbyte[26-bitno];
                else sda_i = 1'b1;
            end
            if (in_sess && !prev_scl && scl) begin
                if (bitno >= 1 && bitno <= 8) begin
                    cap_a = {cap_a[6:0], sda_o};
                    if (!sda_oe) rel_bad++;
                end
                if (bitno >= 10 && bitno <= 17) begin
                    cap_i = {cap_i[6:0], sda_o};
                    if (!sda_oe) rel_bad++;
                end
                if ((bitno == 9 || bitno == 18 || (iack && bitno >= 19 && bitno <= 26)) && sda_oe)
                    rel_bad++;
                if (bitno == 27) mack = sda_oe && sda_o;
            end
            if (done) begin
                done_cnt++; gap = n - stop_n;
                if (prev_done) wide++;
            end
        end
        prev_scl = scl; prev_line = line; prev_done = done;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        starts = 0; stops = 0; frames = 0; done_cnt = 0;
        illegal = 0; low2 = 0; idle_low = 0; rel_bad = 0; wide = 0;
        cap_a = '0; cap_i = '0; mack = 1'b0;
    endtask

    task automatic pulse_go(input logic [6:0] a, input logic [7:0] r);
        @(posedge clk); #1;
        tgt_addr = a; reg_idx = r; go = 1'b1;
        @(posedge clk); #1;
        go = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (done_cnt == 0 && t < 4000) begin
            @(posedge clk); #1; t++;
        end
        chk(done_cnt == 1, {tag, " done seen (R9)"}, done_cnt, 1);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk(scl == 1'b1,     "R1 scl",     scl, 1);
        chk(sda_oe == 1'b1,  "R1 sda_oe",  sda_oe, 1);
        chk(sda_o == 1'b1,   "R1 sda_o",   sda_o, 1);
        chk(done == 1'b0,    "R1 done",    done, 0);
        chk(ack_err == 1'b0, "R1 ack_err", ack_err, 0);
        chk(rd_data == 8'h0, "R1 rd_data", rd_data, 0);
    endtask

    // one full session against the target model
    task automatic t_read(input string tag, input logic [6:0] a, input logic [7:0] r,
                          input logic [7:0] b, input int nk, input logic ia);
        logic [7:0] old_rd;
        old_rd = rd_data;
        clear_mon();
        nacks_left = nk; iack = ia; tbyte = b;
        pulse_go(a, r);
        chk(ack_err == 1'b0, {tag, " R11 ack_err cleared by go"}, ack_err, 0);
        wait_done(tag);
        chk(starts == 1, {tag, " R2 one start"}, starts, 1);
        chk(stops == 1, {tag, " R9 one stop"}, stops, 1);
        chk(gap == 2, {tag, " R9 done two cycles after stop"}, gap, 2);
        chk(wide == 0, {tag, " R9 done one cycle wide"}, wide, 0);
        chk(frames == nk + 1, {tag, " R6 address frames"}, frames, nk + 1);
        chk(cap_a == {a, 1'b1}, {tag, " R5 address and read bit"}, cap_a, {a, 1'b1});
        chk(cap_i == r, {tag, " R7 register index"}, cap_i, r);
        chk(rel_bad == 0, {tag, " R6 R8 released slots"}, rel_bad, 0);
        chk(illegal == 0, {tag, " R4 no edge with clock high"}, illegal, 0);
        chk(low2 == 0 && idle_low == 0, {tag, " R3 clock shape"}, low2 + idle_low, 0);
        if (ia) begin
            chk(mack == 1'b1, {tag, " R8 master acknowledge"}, mack, 1);
            chk(rd_data == b, {tag, " R10 received byte"}, rd_data, b);
            chk(ack_err == 1'b0, {tag, " R11 no error"}, ack_err, 0);
        end else begin
            chk(ack_err == 1'b1, {tag, " R11 error flag"}, ack_err, 1);
            chk(rd_data == old_rd, {tag, " R11 byte kept"}, rd_data, old_rd);
        end
    endtask

    task automatic t_busy_go();
        clear_mon();
        nacks_left = 0; iack = 1'b1; tbyte = 8'h69;
        pulse_go(7'h2B, 8'h81);
        repeat (20) @(posedge clk);
        #1;
        pulse_go(7'h55, 8'h18);   // must be ignored
        wait_done("busy");
        chk(starts == 1, "busy R2 second go ignored", starts, 1);
        chk(cap_a == {7'h2B, 1'b1}, "busy R2 address unchanged", cap_a, {7'h2B, 1'b1});
        chk(cap_i == 8'h81, "busy R2 index unchanged", cap_i, 8'h81);
        chk(rd_data == 8'h69, "busy R10 byte", rd_data, 8'h69);
    endtask

    initial begin
        #200000;
        checks++; errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_read("match", 7'h5A, 8'h3C, 8'hA5, 0, 1'b1);
        t_read("retry", 7'h13, 8'hC7, 8'h0F, 3, 1'b1);
        t_read("regnack", 7'h70, 8'hE2, 8'h77, 0, 1'b0);
        t_read("recover", 7'h01, 8'h00, 8'hF0, 1, 1'b1);
        t_busy_go();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule